// File: doc/BRIEF.md
# Bit-Clock Retimer with Rearming One-Shot

The block takes a serial-audio bit clock that arrives with timing jitter and regenerates it on the rising edges of a faster, clean master clock. The incoming bit clock is sampled by a short shift chain clocked by the master clock. The retimed clock is taken from a fixed tap of that chain, so every output edge lines up with a master edge. The master clock is nominally about seventeen times the bit-clock rate. It is neither an integer multiple of the bit clock nor phase-locked to it.

Once the chain captures a rising bit-clock edge, a counter runs for a fixed number of master cycles and then clears every stage of the chain. The chain is held high until that clear. This turns it into a one-shot with a constant output high time. After the clear, the chain waits to sample a low bit clock before it accepts the next rising edge, so it is always in a known state when that edge arrives. The serial data and word-select lines pass straight through. The block also produces a reference clock at one quarter of the master rate.

Top module: `bck_retimer`

## Requirements
- R1: When bck_in rises between two master edges, bck_out rises at the second rising master edge after that input edge. It does not rise on the first.
- R2: Each bck_out pulse stays high for exactly CLEAR_DELAY - TAP master cycles (8 with the defaults CLEAR_DELAY=9 and TAP=1), whatever the input high time. At master edge CLEAR_DELAY after the capturing edge, every chain stage is cleared.
- R3: A bck_in sequence with rising edges at least 16 master cycles apart, and high and low phases of 8 or 9 cycles, gives exactly one bck_out pulse per input rising edge.
- R4: A bck_in rising edge that arrives while a pulse is active, or while the chain is being cleared and rearmed, produces no output pulse.
- R5: If bck_in is still high when the clear happens, no new pulse follows until bck_in has been sampled low and then rises again.
- R6: data_out equals data_in and ws_out equals ws_in at all times, with no clock delay.
- R7: ref_clk is the master clock divided by four. It is low during reset. It is low after the first master edge following reset release, high after the second and third, low after the fourth, and the pattern repeats.
- R8: While rst (synchronous, active high) is held, bck_out is low. A bck_in that is already high when reset is released is not taken as a rising edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Master clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| bck_in | input | 1 | Jittery bit clock, asynchronous to clk |
| data_in | input | 1 | Serial audio data |
| ws_in | input | 1 | Word select |
| bck_out | output | 1 | Retimed bit clock |
| data_out | output | 1 | data_in passed through |
| ws_out | output | 1 | ws_in passed through |
| ref_clk | output | 1 | Master clock divided by four |

## Verification
The bench drives every bit-clock edge a fraction of a master period after a known rising master edge p, so its cycle index is known. The first sampling stage catches the edge at edge p+1 and the output tap goes high at edge p+2. The bench therefore samples bck_out on the falling edge after p+2 and requires it to have just risen there. It then counts falling-edge samples until bck_out drops and expects eight. It compares the number of output pulses with the number of input edges it expected to be accepted, after each random and directed phase has drained. The passthrough lines are compared a fraction of a nanosecond after each change, and ref_clk is compared on each falling edge against the edge count since reset release.

// File: rtl/bck_retimer_pkg.sv
package bck_retimer_pkg;

    typedef enum logic [1:0] {
        ST_FLUSH    = 2'd0,
        ST_WAIT_LOW = 2'd1,
        ST_ARMED    = 2'd2,
        ST_ACTIVE   = 2'd3
    } os_state_e;

    typedef struct packed {
        logic clear_all;
        logic hold_first;
        logic block_shift;
    } chain_ctrl_t;

    localparam chain_ctrl_t CTRL_SHIFT = '{clear_all: 1'b0, hold_first: 1'b0, block_shift: 1'b0};

    function automatic logic is_last(input int unsigned count, input int unsigned delay);
        return (count == delay - 1);
    endfunction

endpackage

// File: rtl/bck_shift_chain.sv
module bck_shift_chain
    import bck_retimer_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bck_in,
    input  chain_ctrl_t       ctrl,
    output logic [STAGES-1:0] taps
);

    always_ff @(posedge clk) begin
        if (rst || ctrl.clear_all) begin
            taps[0] <= 1'b0;
        end else if (ctrl.hold_first) begin
            taps[0] <= 1'b1;
        end else begin
            taps[0] <= bck_in;
        end
    end

    for (genvar i = 1; i < STAGES; i++) begin : g_stage
        always_ff @(posedge clk) begin
            if (rst || ctrl.clear_all || ctrl.block_shift) begin
                taps[i] <= 1'b0;
            end else begin
                taps[i] <= taps[i-1];
            end
        end
    end

endmodule

// File: rtl/bck_oneshot_ctrl.sv
module bck_oneshot_ctrl
    import bck_retimer_pkg::*;
#(
    parameter int CLEAR_DELAY = 9,
    localparam int CW = $clog2(CLEAR_DELAY + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          first_stage,
    output chain_ctrl_t   ctrl,
    output os_state_e     state,
    output logic [CW-1:0] count
);

    os_state_e     state_nxt;
    logic [CW-1:0] count_nxt;

    always_comb begin
        ctrl      = CTRL_SHIFT;
        state_nxt = state;
        count_nxt = count;
        case (state)
            ST_FLUSH: begin
                ctrl.block_shift = 1'b1;
                state_nxt        = ST_WAIT_LOW;
            end
            ST_WAIT_LOW: begin
                ctrl.block_shift = 1'b1;
                if (!first_stage) begin
                    state_nxt = ST_ARMED;
                end
            end
            ST_ARMED: begin
                if (first_stage) begin
                    ctrl.hold_first = 1'b1;
                    state_nxt       = ST_ACTIVE;
                    count_nxt       = CW'(1);
                end
            end
            default: begin
                ctrl.hold_first = 1'b1;
                if (is_last(int'(count), CLEAR_DELAY)) begin
                    ctrl.clear_all = 1'b1;
                    state_nxt      = ST_FLUSH;
                    count_nxt      = '0;
                end else begin
                    count_nxt = count + CW'(1);
                end
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_FLUSH;
            count <= '0;
        end else begin
            state <= state_nxt;
            count <= count_nxt;
        end
    end

    AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (rst)
        (state == ST_ACTIVE) |-> (int'(count) >= 1 && int'(count) < CLEAR_DELAY)); // R2

    AST_FLUSH_FOLLOWS_CLEAR: assert property (@(posedge clk) disable iff (rst)
        (state == ST_ACTIVE && is_last(int'(count), CLEAR_DELAY)) |=> (state == ST_FLUSH)); // R4

endmodule

// File: rtl/ref_divider.sv
module ref_divider #(
    parameter int DIV_BITS = 2
) (
    input  logic clk,
    input  logic rst,
    output logic ref_o
);

    logic [DIV_BITS-1:0] phase;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase <= '0;
        end else begin
            phase <= phase + DIV_BITS'(1);
        end
    end

    assign ref_o = phase[DIV_BITS-1];

    if (DIV_BITS > 1) begin : g_chk
        AST_REF_HIGH_HOLD: assert property (@(posedge clk) disable iff (rst)
            $rose(ref_o) |=> $stable(ref_o)); // R7
        AST_REF_LOW_HOLD: assert property (@(posedge clk) disable iff (rst)
            $fell(ref_o) |=> $stable(ref_o)); // R7
    end

endmodule

// File: rtl/bck_retimer.sv
module bck_retimer
    import bck_retimer_pkg::*;
#(
    parameter int STAGES      = 2,
    parameter int TAP         = 1,
    parameter int CLEAR_DELAY = 9,
    parameter int DIV_BITS    = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic bck_in,
    input  logic data_in,
    input  logic ws_in,
    output logic bck_out,
    output logic data_out,
    output logic ws_out,
    output logic ref_clk
);

    localparam int CW = $clog2(CLEAR_DELAY + 1);

    if (CLEAR_DELAY <= TAP || TAP >= STAGES || TAP < 1) begin : g_bad_params
        $error("bck_retimer: CLEAR_DELAY must exceed TAP, and TAP must lie inside the chain");
    end

    chain_ctrl_t       ctrl;
    os_state_e         state;
    logic [CW-1:0]     count;
    logic [STAGES-1:0] taps;

    bck_shift_chain #(.STAGES(STAGES)) u_chain (
        .clk    (clk),
        .rst    (rst),
        .bck_in (bck_in),
        .ctrl   (ctrl),
        .taps   (taps)
    );

    bck_oneshot_ctrl #(.CLEAR_DELAY(CLEAR_DELAY)) u_ctrl (
        .clk         (clk),
        .rst         (rst),
        .first_stage (taps[0]),
        .ctrl        (ctrl),
        .state       (state),
        .count       (count)
    );

    ref_divider #(.DIV_BITS(DIV_BITS)) u_div (
        .clk   (clk),
        .rst   (rst),
        .ref_o (ref_clk)
    );

    assign bck_out  = taps[TAP];
    assign data_out = data_in;
    assign ws_out   = ws_in;

    AST_PULSE_HELD: assert property (@(posedge clk) disable iff (rst)
        (state == ST_ACTIVE && int'(count) >= TAP && !is_last(int'(count), CLEAR_DELAY)) |=> bck_out); // R2

    AST_CLEAR_ENDS_PULSE: assert property (@(posedge clk) disable iff (rst)
        (state == ST_ACTIVE && is_last(int'(count), CLEAR_DELAY)) |=> (!bck_out && taps == '0)); // R2

    AST_RISE_ONLY_FROM_ARMED: assert property (@(posedge clk) disable iff (rst)
        $rose(bck_out) |-> (state == ST_ACTIVE && $past(state) == ST_ARMED)); // R4

    AST_RESET_LOW: assert property (@(posedge clk)
        rst |=> !bck_out); // R8

endmodule

// File: tb/bck_retimer_test.sv
`timescale 1ns/1ps
module bck_retimer_test;

    localparam int HIGH_CYCLES = 8;
    localparam int LATENCY     = 2;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic bck_in = 1'b0;
    logic data_in = 1'b0;
    logic ws_in = 1'b0;
    logic bck_out, data_out, ws_out, ref_clk;

    int checks = 0;
    int fails = 0;
    int cyc = 0;
    int rise_cyc = 0;
    int out_pulses = 0;
    int exp_pulses = 0;
    int hi_len = 0;
    logic prev_out = 1'b0;
    bit monitor_on = 1'b0;
    bit done = 1'b0;

    bck_retimer uut (
        .clk      (clk),
        .rst      (rst),
        .bck_in   (bck_in),
        .data_in  (data_in),
        .ws_in    (ws_in),
        .bck_out  (bck_out),
        .data_out (data_out),
        .ws_out   (ws_out),
        .ref_clk  (ref_clk)
    );

    always #2 clk = ~clk;

    always @(posedge clk) cyc = cyc + 1;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    function automatic real frac_ns();
        case ($urandom % 6)
            0: return 0.5;
            1: return 1.0;
            2: return 1.5;
            3: return 2.5;
            4: return 3.0;
            default: return 3.5;
        endcase
    endfunction

    task automatic set_bck(input int wait_edges, input logic v);
        repeat (wait_edges) @(posedge clk);
        #(frac_ns());
        bck_in = v;
        if (v) rise_cyc = cyc;
    endtask

    task automatic check_pass(input string tag);
        data_in = 1'($urandom % 2);
        ws_in   = 1'($urandom % 2);
        #0.2;
        check(data_out == data_in && ws_out == ws_in, tag,
              int'({data_out, ws_out}), int'({data_in, ws_in}));
    endtask

    // Output pulse monitor: rise latency (R1) and high time (R2)
    always @(negedge clk) begin
        if (monitor_on && !rst) begin
            if (bck_out && !prev_out) begin
                check(cyc - rise_cyc == LATENCY, "R1 rise latency", cyc - rise_cyc, LATENCY);
                out_pulses++;
                hi_len = 1;
            end else if (bck_out && prev_out) begin
                hi_len++;
            end else if (!bck_out && prev_out) begin
                check(hi_len == HIGH_CYCLES, "R2 high time", hi_len, HIGH_CYCLES);
            end
            prev_out = bck_out;
        end
    end

    // Watchdog
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        int rel_cyc;
        void'($urandom(32'd2024));

        // R8: output low while reset held, despite toggling input
        for (int i = 0; i < 6; i++) begin
            set_bck(2, ~bck_in);
            @(negedge clk);
            check(bck_out == 1'b0, "R8 low in reset", int'(bck_out), 0);
            check(ref_clk == 1'b0, "R7 ref low in reset", int'(ref_clk), 0);
        end

        // Release reset with bck_in already high
        @(posedge clk);
        #0.5;
        bck_in = 1'b1;
        rst = 1'b0;
        rel_cyc = cyc;
        monitor_on = 1'b1;

        // R7: divide-by-four pattern after release
        for (int j = 1; j <= 20; j++) begin
            @(negedge clk);
            check(int'(ref_clk) == (((cyc - rel_cyc) >> 1) & 1), "R7 ref pattern",
                  int'(ref_clk), ((cyc - rel_cyc) >> 1) & 1);
        end
        check(out_pulses == 0, "R8 high at release ignored", out_pulses, 0);

        set_bck(1, 1'b0);
        repeat (12) @(posedge clk);

        // R3 / R6: random jittered bit clock
        for (int k = 0; k < 40; k++) begin
            set_bck(1, 1'b1);
            exp_pulses++;
            check_pass("R6 passthrough");
            set_bck(8 + int'($urandom % 2), 1'b0);
            check_pass("R6 passthrough");
            repeat (7 + int'($urandom % 2)) @(posedge clk);
        end
        repeat (20) @(posedge clk);
        check(out_pulses == exp_pulses, "R3 pulse count random", out_pulses, exp_pulses);

        // R4: re-rise while pulse active
        set_bck(1, 1'b1);
        exp_pulses++;
        set_bck(3, 1'b0);
        set_bck(2, 1'b1);
        set_bck(6, 1'b0);
        repeat (20) @(posedge clk);
        check(out_pulses == exp_pulses, "R4 rise during active", out_pulses, exp_pulses);

        // R4: re-rise while chain is cleared and rearmed
        set_bck(1, 1'b1);
        exp_pulses++;
        set_bck(9, 1'b0);
        set_bck(1, 1'b1);
        set_bck(10, 1'b0);
        repeat (20) @(posedge clk);
        check(out_pulses == exp_pulses, "R4 rise during clear", out_pulses, exp_pulses);

        // R5: input held high across the clear
        set_bck(1, 1'b1);
        exp_pulses++;
        set_bck(30, 1'b0);
        repeat (20) @(posedge clk);
        check(out_pulses == exp_pulses, "R5 held high single pulse", out_pulses, exp_pulses);
        set_bck(1, 1'b1);
        exp_pulses++;
        set_bck(9, 1'b0);
        repeat (20) @(posedge clk);
        check(out_pulses == exp_pulses, "R5 next rise accepted", out_pulses, exp_pulses);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule